// File: doc/BRIEF.md
# Serial DMA request encoder

This block lives in a peripheral and tells the bus host which DMA channels want service, using one dedicated active-low wire clocked by the bus clock. Local agents raise a one-cycle request or withdrawal strobe for any of eight channels. The block records each strobe in a per-channel pending bitmap and then sends the events one frame at a time. Each frame is a low start bit, the three-bit channel number with the most significant bit first, and an active/inactive flag. One clock of high line follows each frame before the next start bit.

The agents need no arbitration of their own. Several channels can be announced back to back while earlier requests are still outstanding. Pending channels are served in round-robin order, starting after the channel sent last. A later event for a channel that is still pending replaces the earlier one. A `busy` output covers the six clocks of each frame, including its idle gap.

Top module: `dma_req_serializer`

## Requirements
- R1: A synchronous active-high reset drives the line high, clears `busy` and discards every pending event, including strobes seen while reset was high.
- R2: While no frame is in progress the line stays high and `busy` is low.
- R3: Each frame has five data clocks in this order: start bit low, channel bit 2, channel bit 1, channel bit 0, then the flag bit. A high level on the line encodes a 1.
- R4: The flag clock is followed by exactly one clock of high line. `busy` is high for all six clocks of a frame.
- R5: A `set_req[i]` strobe produces a frame for channel i with flag 1. A `drop_req[i]` strobe produces a frame for channel i with flag 0.
- R6: Events for a pending channel are merged, so the channel gets exactly one frame, and that frame carries the flag of the last event. When both strobes of one channel arrive in the same cycle, the flag is 1.
- R7: Among the pending channels, the next one sent is the first found when counting upward, with wrap-around, from the channel sent last. After reset the search starts at channel 0.
- R8: When another channel is pending at the end of a frame, its start bit follows the single gap clock directly, and `busy` stays high.
- R9: When the block is idle, a strobe sampled at clock edge k makes the start bit appear on the line after edge k+1.
- R10: A strobe for the channel that is being sent does not change the current frame. It queues a new frame for that channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| set_req | input | 8 | Per-channel strobe: announce the request as active |
| drop_req | input | 8 | Per-channel strobe: withdraw the request |
| req_line_n | output | 1 | Serial request line, idles high |
| busy | output | 1 | High during each six-clock frame period |

## Verification
The bench decodes the wire on its own and checks every frame's bit order and gap. It also checks the start-bit latency from the strobe, so a design with an extra register, or one that sends the channel bits least significant first, is caught. For every possible last-sent channel, the bench queues all channels and then a sparse set, and checks the round-robin order. A fixed-priority or off-by-one pointer would reorder those frames. It also merges conflicting events for one pending channel, strobes a channel during its own frame, and strobes during reset. A design that sent duplicate frames, dropped the re-queued event, or kept stale state through reset would add or lose frames there.

// File: rtl/dma_req_serializer.sv
`timescale 1ns/1ps
module dma_req_serializer #(
  parameter int CH_W = 3,
  localparam int NCH = 1 << CH_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_req,
  input  logic [NCH-1:0] drop_req,
  output logic           req_line_n,
  output logic           busy
);
  localparam int PH_ACT = CH_W + 1;
  localparam int PH_GAP = CH_W + 2;
  localparam int PH_W   = $clog2(PH_GAP + 1);

  logic [NCH-1:0]  pend, actv;
  logic [CH_W-1:0] last, cur, pick, idx;
  logic            cur_act, found, grant;
  logic [PH_W-1:0] ph;

  always_comb begin
    found = 1'b0;
    pick  = last;
    idx   = last;
    for (int k = 1; k <= NCH; k++) begin
      idx = last + CH_W'(k);
      if (!found && pend[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  assign grant = found && (!busy || ph == PH_W'(PH_GAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      actv    <= '0;
      last    <= '1;
      cur     <= '0;
      cur_act <= 1'b0;
      busy    <= 1'b0;
      ph      <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (set_req[i]) begin
          pend[i] <= 1'b1;
          actv[i] <= 1'b1;
        end else if (drop_req[i]) begin
          pend[i] <= 1'b1;
          actv[i] <= 1'b0;
        end else if (grant && pick == CH_W'(i)) begin
          pend[i] <= 1'b0;
        end
      end
      if (grant) begin
        busy    <= 1'b1;
        ph      <= '0;
        cur     <= pick;
        cur_act <= actv[pick];
        last    <= pick;
      end else if (busy) begin
        if (ph == PH_W'(PH_GAP)) busy <= 1'b0;
        else                     ph   <= ph + 1'b1;
      end
    end
  end

  always_comb begin
    req_line_n = 1'b1;
    if (busy) begin
      if (ph == '0) req_line_n = 1'b0;
      if (ph == PH_W'(PH_ACT)) req_line_n = cur_act;
      for (int b = 0; b < CH_W; b++)
        if (ph == PH_W'(b + 1)) req_line_n = cur[CH_W-1-b];
    end
  end
endmodule

// File: rtl/dma_req_serializer_chk.sv
`timescale 1ns/1ps
module dma_req_serializer_chk #(
  parameter int CH_W = 3,
  localparam int PH_GAP = CH_W + 2,
  localparam int PH_W   = $clog2(PH_GAP + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            req_line_n,
  input logic            busy,
  input logic [PH_W-1:0] ph
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (req_line_n && !busy));

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> req_line_n);

  assert_start_low_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && ph == '0) |-> !req_line_n);

  assert_gap_high_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && ph == PH_W'(PH_GAP)) |-> req_line_n);

  assert_frame_runs_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && ph != PH_W'(PH_GAP)) |=> (busy && ph == $past(ph) + 1'b1));

  assert_high_before_start_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && ph == '0) |-> $past(req_line_n));
endmodule

bind dma_req_serializer dma_req_serializer_chk #(.CH_W(CH_W)) chk_i (
  .clk(clk), .rst(rst), .req_line_n(req_line_n), .busy(busy), .ph(ph)
);

// File: tb/dma_req_serializer_test.sv
`timescale 1ns/1ps
module dma_req_serializer_test;
  logic clk = 0, rst = 1;
  logic [7:0] set_s = 0, ab_s = 0;
  logic req_line_n, busy;
  int cyc = 0, nrun = 0, nfail = 0;
  int fch[0:63], fact[0:63], fst[0:63];
  int nfr = 0, dst = 0, fc = 0, fstart = 0;

  dma_req_serializer uut (.clk(clk), .rst(rst), .set_req(set_s), .drop_req(ab_s),
                          .req_line_n(req_line_n), .busy(busy));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst) dst = 0;
    else case (dst)
      0: if (!req_line_n) begin
           dst = 1; fstart = cyc; fc = 0;
           chk(busy === 1'b1, "R4 busy at start", int'(busy), 1);
         end
      1, 2, 3: begin fc = (fc << 1) | int'(req_line_n); dst++; end
      4: begin
           if (nfr < 64) begin
             fch[nfr] = fc; fact[nfr] = int'(req_line_n); fst[nfr] = fstart;
           end
           nfr++; dst = 5;
         end
      default: begin
           chk(req_line_n === 1'b1, "R4 gap high", int'(req_line_n), 1);
           chk(busy === 1'b1, "R4 busy in gap", int'(busy), 1);
           dst = 0;
         end
    endcase
  end

  task automatic pulse(input logic [7:0] sm, input logic [7:0] am, output int ts);
    @(negedge clk); set_s = sm; ab_s = am;
    @(negedge clk); ts = cyc; set_s = 0; ab_s = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_frame(input int i, input int ch, input int a, input int st, input string req);
    chk(nfr > i, {req, " frame present"}, nfr, i + 1);
    if (nfr > i) begin
      chk(fch[i] == ch, {req, " channel"}, fch[i], ch);
      chk(fact[i] == a, {req, " flag"}, fact[i], a);
      if (st >= 0) chk(fst[i] == st, {req, " start cycle"}, fst[i], st);
    end
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    int ts;
    int e;
    logic [7:0] m;
    // R1: strobes during reset are discarded
    set_s = 8'hFF; wait_n(3); set_s = 0; ab_s = 8'hFF; wait_n(1); ab_s = 0;
    wait_n(1); rst = 0;
    wait_n(1);
    chk(req_line_n === 1'b1, "R1 line after reset", int'(req_line_n), 1);
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    wait_n(20);
    chk(nfr == 0, "R1 no frame after reset", nfr, 0);
    chk(req_line_n === 1'b1 && busy === 1'b0, "R2 idle", int'(req_line_n), 1);

    // R3 R5 R9: every channel with both flags, from idle
    for (int ch = 0; ch < 8; ch++) begin
      for (int a = 0; a < 2; a++) begin
        nfr = 0;
        m = 8'(1) << ch;
        if (a == 1) pulse(m, 8'h00, ts); else pulse(8'h00, m, ts);
        wait_n(10);
        chk(nfr == 1, "R5 one frame", nfr, 1);
        expect_frame(0, ch, a, ts + 1, "R3 R5 R9");
        chk(req_line_n === 1'b1 && busy === 1'b0, "R2 idle after frame", int'(busy), 0);
      end
    end

    // R6: merging of events on a pending channel
    nfr = 0;
    pulse(8'h01, 8'h00, ts);
    pulse(8'h20, 8'h00, e);
    pulse(8'h00, 8'h20, e);
    pulse(8'h00, 8'h20, e);
    wait_n(20);
    chk(nfr == 2, "R6 merged count", nfr, 2);
    expect_frame(0, 0, 1, ts + 1, "R6");
    expect_frame(1, 5, 0, ts + 7, "R6 R8");

    nfr = 0;
    pulse(8'h01, 8'h00, ts);
    pulse(8'h00, 8'h40, e);
    pulse(8'h40, 8'h00, e);
    pulse(8'h04, 8'h04, e);
    wait_n(24);
    chk(nfr == 3, "R6 merged count 2", nfr, 3);
    expect_frame(0, 0, 1, ts + 1, "R6");
    expect_frame(1, 2, 1, ts + 7, "R6 same-cycle");
    expect_frame(2, 6, 1, ts + 13, "R6 later wins");

    // R10: strobe during own frame re-queues the channel
    nfr = 0;
    pulse(8'h10, 8'h00, ts);
    wait_n(1);
    pulse(8'h00, 8'h10, e);
    wait_n(16);
    chk(nfr == 2, "R10 count", nfr, 2);
    expect_frame(0, 4, 1, ts + 1, "R10 unchanged");
    expect_frame(1, 4, 0, ts + 7, "R10 requeued");

    // R7 R8: round robin from every last-sent channel
    for (int L = 0; L < 8; L++) begin
      nfr = 0;
      pulse(8'(1) << L, 8'h00, ts);
      wait_n(8);
      nfr = 0;
      pulse(8'hFF, 8'h00, ts);
      wait_n(8 * 6 + 4);
      chk(nfr == 8, "R7 all count", nfr, 8);
      for (int i = 0; i < 8; i++)
        expect_frame(i, (L + 1 + i) % 8, 1, ts + 1 + 6 * i, "R7 R8 order");
      nfr = 0;
      m = 8'h45 ^ (8'(1) << L);
      pulse(8'h00, m, ts);
      wait_n(8 * 6 + 4);
      chk(nfr == $countones(m), "R7 sparse count", nfr, $countones(m));
      e = 0;
      for (int k = 1; k <= 8; k++) begin
        if (m[(L + k) % 8]) begin
          expect_frame(e, (L + k) % 8, 0, ts + 1 + 6 * e, "R7 sparse");
          e++;
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule